// File: doc/BRIEF.md
# Four-Channel DMA Request Arbiter

This block decides which of four DMA request lines is served next. When no service is in progress, it looks at the requests that are active and unmasked and picks one. It then raises a hold request toward the bus owner and asserts exactly one acknowledge line. That grant stays fixed until the transfer sequencer pulses its completion input. Only then are the grant and the hold request dropped and the requests looked at again.

Two priority schemes are available, selected by one configuration bit. In the fixed scheme, a lower channel number always wins. In the rotating scheme, the channel that was served most recently becomes the last in line, and the channels after it move up in order. The polarity of the incoming requests and of the outgoing acknowledges can each be set by its own configuration bit. This lets the block sit between devices with either signalling convention.

Top module: `dma_prio_arbiter`

## Requirements
- R1: While reset is asserted, and on leaving it, holdReq is low and every ackOut pin sits at its inactive level. The inactive level is 1 when cfgAckActiveHigh is 0 and 0 when it is 1. The rotation pointer starts with channel 0 as highest priority.
- R2: When cfgRotate is 0, the winner is the lowest-numbered channel that is both requesting and unmasked.
- R3: When cfgRotate is 1, after channel k completes service, the search order is k+1, k+2, k+3, k (modulo 4).
- R4: The same request pattern gives the fixed-order winner when cfgRotate is 0 and the rotated-order winner when it is 1. The configuration bit is applied at each arbitration.
- R5: When cfgReqActiveLow is 1, a reqRaw bit at 0 counts as a request. When it is 0, a reqRaw bit at 1 counts as a request.
- R6: When cfgAckActiveHigh is 1, the granted channel's ackOut bit is 1 and the others are 0. When it is 0, the granted bit is 0 and the others are 1.
- R7: A channel whose maskBits bit is 1 is never granted. If no unmasked channel is requesting, no grant is made.
- R8: At most one channel is granted at a time. The grant does not change while service is in progress, whatever reqRaw and maskBits do.
- R9: The rotation pointer moves only when service completes, not when a grant is issued. It moves in either priority mode.
- R10: A grant appears on ackOut, with holdReq high, on the first clock edge at which the block is idle and an eligible request is present. The clock edge that samples serviceDone high removes both. holdReq is high exactly while a grant is held.
- R11: A serviceDone pulse while idle has no effect: the pointer and the outputs stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgRotate | input | 1 | 1 selects rotating priority, 0 selects fixed priority |
| cfgReqActiveLow | input | 1 | 1 makes reqRaw active low |
| cfgAckActiveHigh | input | 1 | 1 makes ackOut active high |
| reqRaw | input | 4 | Raw request lines, one per channel |
| maskBits | input | 4 | Per-channel mask; 1 excludes the channel |
| serviceDone | input | 1 | One-cycle pulse from the sequencer ending the current service |
| ackOut | output | 4 | Per-channel acknowledge, polarity set by cfgAckActiveHigh |
| holdReq | output | 1 | Bus hold request, high while a grant is held |

## Verification
A corrupted rotation pointer does not show at once. It shows on the next rotating-mode arbitration in which two or more channels compete: that arbitration picks the wrong acknowledge line, one cycle after the request is seen. A grant register that drifts or takes on a second bit shows on the acknowledge pins in the very next cycle, even while the requests are being changed under an active service. The bench therefore keeps a reference pointer and compares the pins in every cycle of each service. It also ends every service before the next one starts, so a pointer error surfaces within a single transaction.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

  // Strobes from the control FSM to the grant datapath
  typedef struct packed {
    logic grantLoad;   // capture the arbitration winner this edge
    logic grantClear;  // end of service: drop grant, advance pointer
  } arbStrobes_t;

endpackage

// File: rtl/dma_arb_control.sv
module dma_arb_control
  import dma_arb_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        anyPending,
  input  logic        serviceDone,
  output arbStrobes_t strobes,
  output logic        busy
);

  logic busyQ;

  always_comb begin
    strobes.grantLoad  = !busyQ && anyPending;
    strobes.grantClear = busyQ && serviceDone;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                   busyQ <= 1'b0;
    else if (strobes.grantClear) busyQ <= 1'b0;
    else if (strobes.grantLoad)  busyQ <= 1'b1;
  end

  assign busy = busyQ;

  // R10: completion ends the service on the next edge
  p_clear_ends_r10: assert property (@(posedge clk) disable iff (!rstN)
    strobes.grantClear |=> !busyQ);

  // R10: an idle edge with an eligible request starts a service
  p_load_starts_r10: assert property (@(posedge clk) disable iff (!rstN)
    strobes.grantLoad |=> busyQ);

  // R11: completion while idle does not start anything
  p_idle_done_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!busyQ && serviceDone && !anyPending) |=> !busyQ);

endmodule

// File: rtl/dma_arb_datapath.sv
module dma_arb_datapath
  import dma_arb_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgRotate,
  input  logic              cfgReqActiveLow,
  input  logic              cfgAckActiveHigh,
  input  logic [NUM_CH-1:0] reqRaw,
  input  logic [NUM_CH-1:0] maskBits,
  input  arbStrobes_t       strobes,
  output logic              anyPending,
  output logic [NUM_CH-1:0] grantVec,
  output logic [NUM_CH-1:0] ackOut
);

  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);

  logic [NUM_CH-1:0] eligible;
  logic [NUM_CH-1:0] pickVec;
  logic [NUM_CH-1:0] grantQ;
  logic [CH_W-1:0]   topQ;
  logic [CH_W-1:0]   topCh;
  logic [CH_W-1:0]   servedIdx;
  logic [CH_W-1:0]   nextTop;

  // Per-channel request polarity and masking
  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    logic reqLive;
    assign reqLive     = cfgReqActiveLow ? !reqRaw[c] : reqRaw[c];
    assign eligible[c] = reqLive && !maskBits[c];
    assign ackOut[c]   = cfgAckActiveHigh ? grantQ[c] : !grantQ[c];
  end

  assign anyPending = |eligible;
  assign topCh      = cfgRotate ? topQ : '0;

  // Search from topCh upward, wrapping
  always_comb begin
    logic found;
    found   = 1'b0;
    pickVec = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      int idx;
      idx = (int'(topCh) + i) % NUM_CH;
      if (!found && eligible[idx]) begin
        pickVec[idx] = 1'b1;
        found        = 1'b1;
      end
    end
  end

  // Encode the channel currently held
  always_comb begin
    servedIdx = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (grantQ[i]) servedIdx = CH_W'(i);
    end
  end

  assign nextTop = (servedIdx == LAST_CH) ? '0 : servedIdx + 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      grantQ <= '0;
      topQ   <= '0;
    end else if (strobes.grantClear) begin
      grantQ <= '0;
      topQ   <= nextTop;
    end else if (strobes.grantLoad) begin
      grantQ <= pickVec;
    end
  end

  assign grantVec = grantQ;

  // R8: never more than one channel granted
  p_grant_onehot_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grantQ));

  // R8: grant frozen until completion
  p_grant_stable_r8: assert property (@(posedge clk) disable iff (!rstN)
    ((|grantQ) && !strobes.grantClear) |=> $stable(grantQ));

  // R7: a masked channel is never loaded
  p_mask_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.grantLoad |=> ((grantQ & $past(maskBits)) == '0));

  // R9: pointer moves only on completion
  p_ptr_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.grantClear |=> $stable(topQ));

  // R2: in fixed mode an eligible channel 0 always wins
  p_fixed_ch0_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.grantLoad && !cfgRotate && eligible[0]) |=> grantQ[0]);

endmodule

// File: rtl/dma_prio_arbiter.sv
module dma_prio_arbiter
  import dma_arb_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgRotate,
  input  logic              cfgReqActiveLow,
  input  logic              cfgAckActiveHigh,
  input  logic [NUM_CH-1:0] reqRaw,
  input  logic [NUM_CH-1:0] maskBits,
  input  logic              serviceDone,
  output logic [NUM_CH-1:0] ackOut,
  output logic              holdReq
);

  arbStrobes_t       strobes;
  logic              anyPending;
  logic              busy;
  logic [NUM_CH-1:0] grantVec;

  dma_arb_control u_control (
    .clk         (clk),
    .rstN        (rstN),
    .anyPending  (anyPending),
    .serviceDone (serviceDone),
    .strobes     (strobes),
    .busy        (busy)
  );

  dma_arb_datapath #(.NUM_CH(NUM_CH)) u_datapath (
    .clk              (clk),
    .rstN             (rstN),
    .cfgRotate        (cfgRotate),
    .cfgReqActiveLow  (cfgReqActiveLow),
    .cfgAckActiveHigh (cfgAckActiveHigh),
    .reqRaw           (reqRaw),
    .maskBits         (maskBits),
    .strobes          (strobes),
    .anyPending       (anyPending),
    .grantVec         (grantVec),
    .ackOut           (ackOut)
  );

  assign holdReq = busy;

  // R10: hold request tracks the held grant
  p_hold_matches_r10: assert property (@(posedge clk) disable iff (!rstN)
    holdReq == (|grantVec));

endmodule

// File: tb/dma_prio_arbiter_bench.sv
`timescale 1ns/1ps
module dma_prio_arbiter_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgRotate = 1'b0;
  logic       cfgReqActiveLow = 1'b0;
  logic       cfgAckActiveHigh = 1'b0;
  logic [3:0] reqRaw = 4'h0;
  logic [3:0] maskBits = 4'h0;
  logic       serviceDone = 1'b0;
  logic [3:0] ackOut;
  logic       holdReq;

  always #2.5 clk = ~clk;

  dma_prio_arbiter u_dma_prio_arbiter (
    .clk(clk), .rstN(rstN), .cfgRotate(cfgRotate),
    .cfgReqActiveLow(cfgReqActiveLow), .cfgAckActiveHigh(cfgAckActiveHigh),
    .reqRaw(reqRaw), .maskBits(maskBits), .serviceDone(serviceDone),
    .ackOut(ackOut), .holdReq(holdReq)
  );

  typedef struct {
    logic [3:0] ack;
    logic       hold;
    string      tag;
  } expItem_t;

  expItem_t expQ[$];
  int errors = 0;
  int checks = 0;
  int modelTop = 0;
  bit finished = 0;

  function automatic logic [3:0] ackPins(input logic [3:0] oneHot);
    return cfgAckActiveHigh ? oneHot : ~oneHot;
  endfunction

  task automatic compare(input logic [3:0] a, input logic h,
                         input logic [3:0] ea, input logic eh, input string tag);
    checks++;
    if (a !== ea || h !== eh) begin
      errors++;
      $display("FAIL %s: ack=%b hold=%b expected ack=%b hold=%b", tag, a, h, ea, eh);
    end
  endtask

  // Monitor: pops one expectation per falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (expQ.size() > 0) begin
        expItem_t e;
        e = expQ.pop_front();
        compare(ackOut, holdReq, e.ack, e.hold, e.tag);
      end
    end
  end

  task automatic pushExp(input logic [3:0] oneHot, input logic h, input string tag);
    expItem_t e;
    e.ack = ackPins(oneHot);
    e.hold = h;
    e.tag = tag;
    expQ.push_back(e);
  endtask

  // Driver: one full service, expectations derived from the reference model
  task automatic serve(input logic [3:0] req, input logic [3:0] mask,
                       input bit rot, input bit reqLow, input bit ackHigh,
                       input string tag);
    int top;
    int ch;
    logic [3:0] elig;
    @(negedge clk);
    cfgRotate = rot;
    cfgReqActiveLow = reqLow;
    cfgAckActiveHigh = ackHigh;
    reqRaw = reqLow ? ~req : req;
    maskBits = mask;
    elig = req & ~mask;
    top = rot ? modelTop : 0;
    ch = -1;
    for (int i = 0; i < 4; i++) begin
      int idx;
      idx = (top + i) % 4;
      if (ch < 0 && elig[idx]) ch = idx;
    end
    @(posedge clk); #1;
    if (ch < 0) begin
      pushExp(4'h0, 1'b0, "R7");
      @(posedge clk); #1;
      pushExp(4'h0, 1'b0, "R7");
      @(negedge clk);
      reqRaw = reqLow ? 4'hF : 4'h0;
      return;
    end
    pushExp(4'(1 << ch), 1'b1, tag);
    for (int n = 0; n < 2; n++) begin
      @(negedge clk);
      reqRaw = 4'($urandom);
      maskBits = 4'($urandom);
      @(posedge clk); #1;
      pushExp(4'(1 << ch), 1'b1, "R8");
    end
    @(negedge clk);
    serviceDone = 1'b1;
    reqRaw = reqLow ? 4'hF : 4'h0;
    @(posedge clk); #1;
    pushExp(4'h0, 1'b0, "R10");
    modelTop = (ch + 1) % 4;
    @(negedge clk);
    serviceDone = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    compare(ackOut, holdReq, 4'hF, 1'b0, "R1");   // in reset, active-low ack
    rstN = 1'b1;
    @(negedge clk);
    compare(ackOut, holdReq, 4'hF, 1'b0, "R1");

    // R2: fixed order, lowest number wins
    serve(4'b1010, 4'h0, 0, 0, 0, "R2");
    serve(4'b1100, 4'h0, 0, 0, 1, "R6");          // active-high ack
    // R5: active-low request lines
    serve(4'b0110, 4'h0, 0, 1, 1, "R5");
    // R7: masked winner skipped, fully masked gives no grant
    serve(4'b0011, 4'b0001, 0, 0, 0, "R7");
    serve(4'b0101, 4'b0101, 0, 0, 1, "R7");
    // R3/R9: last served is ch1, so rotation starts at ch2
    serve(4'b1111, 4'h0, 1, 0, 1, "R3");          // expect ch2
    serve(4'b1001, 4'h0, 1, 0, 1, "R3");          // top 3: expect ch3
    serve(4'b1001, 4'h0, 1, 0, 1, "R9");          // top 0: expect ch0
    // R4: same pattern, fixed vs rotating (top now 1)
    serve(4'b0101, 4'h0, 0, 0, 0, "R4");          // fixed: ch0
    serve(4'b0101, 4'h0, 1, 0, 0, "R4");          // rotating from 1: ch2
    // R11: completion pulse while idle leaves pointer (3) alone
    @(negedge clk);
    serviceDone = 1'b1;
    @(posedge clk); #1;
    pushExp(4'h0, 1'b0, "R11");
    @(negedge clk);
    serviceDone = 1'b0;
    serve(4'b0011, 4'h0, 1, 0, 1, "R11");         // top 3: ch0

    for (int t = 0; t < 60; t++) begin
      logic [3:0] rq;
      logic [3:0] mk;
      bit rot;
      rq = 4'($urandom);
      mk = ($urandom % 4 == 0) ? 4'($urandom) : 4'h0;
      rot = 1'($urandom);
      serve(rq, mk, rot, 1'($urandom), 1'($urandom), rot ? "R3" : "R2");
    end

    wait (expQ.size() == 0);
    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL R10: watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule